// File: doc/BRIEF.md
# Quarter-Rate Complex-to-Real Converter with Zero Stuffing

This block sits behind a decimate-by-two filter. It takes complex baseband pairs (I and Q) that arrive at half the converter sample rate. It multiplies each pair by a complex carrier at one eighth of the converter rate and keeps only the real part of the product. At the decimated rate that carrier is exactly a quarter of the stage's own sample rate. The real part therefore walks through the four-step rotation I, -Q, -I, Q. This moves the complex band to the centre of the real Nyquist zone and needs no multiplier.

A stuffing control selects between two output modes. In the first, one real sample leaves for each accepted pair, so the stream runs at half the converter rate. In the second, the output is valid on every clock and a zero sample follows each real sample, which lifts the stream back to the full converter rate. The mirrored image that the zeros create is left in place on purpose.

Top module: `fs8_real_conv`

## Requirements
- R1: A synchronous active-high reset clears the output to valid low and data zero on the following clock, and returns the rotation to its first step. The first pair accepted after reset therefore produces I.
- R2: For the k-th pair accepted since reset, counting from k = 0, the output one clock later is I when k mod 4 = 0, -Q when k mod 4 = 1, -I when k mod 4 = 2 and Q when k mod 4 = 3.
- R3: Only cycles with the input valid set move the rotation forward. Idle cycles, of any number, leave the rotation step unchanged.
- R4: Negation saturates. Negating the most negative sample value gives the most positive value, and every other value is negated exactly.
- R5: With stuffing off, the output valid equals the input valid of the previous clock. The output data is zero in any cycle whose valid is low.
- R6: With stuffing on, the output valid is high on every clock after reset. The data carries the rotated sample in the clock after an accepted pair and zero in every other clock. Pairs presented on alternate clocks therefore give a real, zero, real, zero output.
- R7: The stuffing control takes effect on the next clock and does not disturb the rotation step, so the sequence of R2 continues across a mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stuff_en | input | 1 | 1: insert a zero sample after each real sample |
| pair_valid | input | 1 | An I/Q pair is presented this cycle |
| pair_i | input | 14 | In-phase sample, signed two's complement |
| pair_q | input | 14 | Quadrature sample, signed two's complement |
| real_valid | output | 1 | Output sample valid |
| real_data | output | 14 | Real output sample, signed two's complement |

## Verification
A run of back-to-back pairs with distinct I and Q values shows which of the four rotation steps is applied to each pair. Swapping I and Q, or swapping the signs, would produce a visible mismatch. Irregular gaps between pairs separate a rotation that counts accepted pairs from one that counts clocks. Extreme values placed on the negating steps expose a negation that wraps instead of saturating. Alternate-clock input with stuffing on, a mode switch in mid-sequence and a reset in mid-sequence show the zero placement, the continuity of the rotation across modes, and the return to the first step.

// File: rtl/fs8_pkg.sv
package fs8_pkg;

    localparam int SAMPLE_W = 14;
    localparam int STEP_W   = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    localparam sample_t SAMPLE_MAX = sample_t'((1 << (SAMPLE_W-1)) - 1);
    localparam sample_t SAMPLE_MIN = sample_t'(-(1 << (SAMPLE_W-1)));

    typedef struct packed {
        sample_t i;
        sample_t q;
    } iq_t;

    typedef enum logic [STEP_W-1:0] {
        STEP_POS_I = 2'd0,
        STEP_NEG_Q = 2'd1,
        STEP_NEG_I = 2'd2,
        STEP_POS_Q = 2'd3
    } step_e;

    function automatic sample_t neg_sat(input sample_t v);
        if (v == SAMPLE_MIN) return SAMPLE_MAX;
        return -v;
    endfunction

    function automatic sample_t real_of(input iq_t s, input step_e st);
        unique case (st)
            STEP_POS_I: return s.i;
            STEP_NEG_Q: return neg_sat(s.q);
            STEP_NEG_I: return neg_sat(s.i);
            default:    return s.q;
        endcase
    endfunction

endpackage

// File: rtl/fs8_step_ctr.sv
module fs8_step_ctr
    import fs8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output step_e step
);

    logic [STEP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    assign step = step_e'(cnt_q);

    // R3
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cnt_q));

    // R1
    step_reset_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

endmodule

// File: rtl/fs8_rotator.sv
module fs8_rotator
    import fs8_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  iq_t     pair,
    input  step_e   step,
    output sample_t mixed
);

    assign mixed = real_of(pair, step);

    // R4
    neg_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && step == STEP_NEG_I && pair.i == SAMPLE_MIN) |-> (mixed == SAMPLE_MAX));

endmodule

// File: rtl/fs8_out_stage.sv
module fs8_out_stage
    import fs8_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stuff_en,
    input  logic    in_valid,
    input  sample_t in_data,
    output logic    out_valid,
    output sample_t out_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= stuff_en | in_valid;
            out_data  <= in_valid ? in_data : '0;
        end
    end

    // R6
    stuff_valid_chk: assert property (@(posedge clk) disable iff (rst)
        stuff_en |=> out_valid);

    // R5
    plain_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !stuff_en |=> (out_valid == $past(in_valid)));

    // R6
    zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (out_data == '0));

endmodule

// File: rtl/fs8_real_conv.sv
module fs8_real_conv
    import fs8_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stuff_en,
    input  logic                       pair_valid,
    input  logic signed [SAMPLE_W-1:0] pair_i,
    input  logic signed [SAMPLE_W-1:0] pair_q,
    output logic                       real_valid,
    output logic signed [SAMPLE_W-1:0] real_data
);

    iq_t     pair;
    step_e   step;
    sample_t mixed;

    assign pair.i = pair_i;
    assign pair.q = pair_q;

    fs8_step_ctr u_step (
        .clk     (clk),
        .rst     (rst),
        .advance (pair_valid),
        .step    (step)
    );

    fs8_rotator u_rot (
        .clk   (clk),
        .rst   (rst),
        .valid (pair_valid),
        .pair  (pair),
        .step  (step),
        .mixed (mixed)
    );

    fs8_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .stuff_en  (stuff_en),
        .in_valid  (pair_valid),
        .in_data   (mixed),
        .out_valid (real_valid),
        .out_data  (real_data)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (!real_valid && real_data == '0));

endmodule

// File: tb/fs8_real_conv_test.sv
module fs8_real_conv_test;
    import fs8_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stuff_en = 1'b0;
    logic pair_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] pair_i = '0;
    logic signed [SAMPLE_W-1:0] pair_q = '0;
    logic real_valid;
    logic signed [SAMPLE_W-1:0] real_data;

    always #4 clk = ~clk;

    fs8_real_conv uut (
        .clk        (clk),
        .rst        (rst),
        .stuff_en   (stuff_en),
        .pair_valid (pair_valid),
        .pair_i     (pair_i),
        .pair_q     (pair_q),
        .real_valid (real_valid),
        .real_data  (real_data)
    );

    typedef struct {
        logic  v;
        int    d;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   m_step   = 0;
    bit   finished = 0;

    localparam int VMAX = (1 << (SAMPLE_W-1)) - 1;
    localparam int VMIN = -(1 << (SAMPLE_W-1));

    function automatic int negs(input int v);
        return (v == VMIN) ? VMAX : -v;
    endfunction

    function automatic int model_mix(input int i, input int q, input int k);
        case (k % 4)
            0: return i;
            1: return negs(q);
            2: return negs(i);
            default: return q;
        endcase
    endfunction

    task automatic drive(input bit r, input bit pad, input bit v,
                         input int i, input int q, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; stuff_en = pad; pair_valid = v;
        pair_i = SAMPLE_W'(i); pair_q = SAMPLE_W'(q);
        e.tag = tag;
        if (r) begin
            e.v = 1'b0; e.d = 0; m_step = 0;
        end else begin
            e.v = pad | v;
            e.d = v ? model_mix(i, q, m_step) : 0;
            if (v) m_step = m_step + 1;
        end
        exp_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (real_valid !== e.v || int'(real_data) != e.d) begin
                    n_fail++;
                    $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                             e.tag, real_valid, real_data, e.v, e.d);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1, 0, 0, 0, 0, "R1");
        drive(1, 1, 1, 55, 66, "R1");
        // R2 R5: back-to-back pairs, stuffing off
        for (int k = 0; k < 8; k++)
            drive(0, 0, 1, 100 + k, -200 - 3*k, "R2");
        drive(0, 0, 0, 9, 9, "R5");
        // R3: irregular gaps
        for (int k = 0; k < 6; k++) begin
            for (int g = 0; g < k; g++) drive(0, 0, 0, 77, 88, "R3");
            drive(0, 0, 1, 1000 + 7*k, 500 - 11*k, "R3");
        end
        // R4: extremes on every step
        for (int k = 0; k < 8; k++)
            drive(0, 0, 1, (k % 2) ? VMAX : VMIN, (k % 2) ? VMIN : VMAX, "R4");
        // R6: stuffing on, pairs on alternate clocks
        for (int k = 0; k < 8; k++) begin
            drive(0, 1, 1, 300 + k, -40 - k, "R6");
            drive(0, 1, 0, 1, 2, "R6");
        end
        // R7: mode change in mid-sequence
        drive(0, 0, 1, 11, 22, "R7");
        drive(0, 1, 1, 33, 44, "R7");
        drive(0, 1, 0, 0, 0, "R7");
        drive(0, 0, 1, 55, 66, "R7");
        drive(0, 0, 0, 0, 0, "R7");
        drive(0, 1, 1, 77, 88, "R7");
        // R1: reset in mid-sequence restarts the rotation
        drive(0, 0, 1, 5, 6, "R1");
        drive(1, 0, 1, 5, 6, "R1");
        drive(0, 0, 1, 123, 456, "R1");
        drive(0, 0, 1, 123, 456, "R2");
        drive(0, 0, 0, 0, 0, "R5");
        drive(0, 0, 0, 0, 0, "R5");
        wait (exp_q.size() == 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule